// File: doc/BRIEF.md
# Raster Sync and Frame Interrupt Generator

This block walks a raster position across a display frame, one position per pixel clock, and derives the timing signals that a video output stage needs. A horizontal position counter runs from zero to a programmable maximum scan position and then wraps. Each wrap advances a scanline counter, which wraps in turn after a programmable last line. Horizontal and vertical sync pulses (both active low) and a frame interrupt level are set and cleared at fixed points of the raster. Between those points they keep their value.

The current position and an in-frame window flag are exported for downstream pixel fetch and colour logic, together with a one-cycle end-of-line strobe. All events are decoded from the registered position of the current cycle, so each event becomes visible on the outputs one position later. Vertical sync ends halfway along its final scanline rather than at a line boundary. The interrupt is raised at the start of the last displayed pixel line and dropped at the start of the next frame.

Constraints on the parameters: `HSYNC_END` lies in 1 .. `H_MAX`-1 and differs from `H_MAX`/2, `VSYNC_END_LINE` and `LAST_PIX_LINE` lie in 1 .. `V_MAX`, and `PIX_XMIN` is greater than zero.

Top module: `raster_sync_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is x_o=0, y_o=0, hsync_n_o=1, vsync_n_o=1, irq_o=0, eol_o=0 and in_frame_o=0.
- R2: x_o rises by one at every clock edge and wraps to 0 on the edge after it equals `H_MAX`.
- R3: y_o holds while x_o is below `H_MAX`. On the edge where x_o wraps, y_o rises by one, and it goes from `V_MAX` back to 0.
- R4: eol_o is high for exactly one cycle per scanline: the cycle in which x_o is 0 following a wrap. It is low in the reset state.
- R5: hsync_n_o is 0 exactly when 1 <= x_o <= `HSYNC_END`, and 1 otherwise.
- R6: vsync_n_o goes to 0 at position (x=1, y=0) and returns to 1 at position (x=`H_MAX`/2+1, y=`VSYNC_END_LINE`). It is 1 at (x=0, y=0).
- R7: irq_o goes to 1 at position (x=1, y=`LAST_PIX_LINE`) and stays 1 up to and including the next (x=0, y=0). It goes to 0 at (x=1, y=0).
- R8: in_frame_o is 1 exactly when y_o < `LAST_PIX_LINE` and `PIX_XMIN` <= x_o < `PIX_XMAX`.
- R9: Raising `rst` in the middle of a frame returns every output to the R1 state on the next edge. Counting restarts from there once `rst` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| irq_o | output | 1 | Frame interrupt level |
| eol_o | output | 1 | End-of-line strobe, high in the first position of each line |
| in_frame_o | output | 1 | Current position lies inside the pixel window |
| x_o | output | $clog2(H_MAX+1) | Horizontal position |
| y_o | output | $clog2(V_MAX+1) | Scanline number |

## Verification
Some properties are local in time, and the embedded assertions check them on every cycle. These are the counter steps and wraps, the line hold, eol_o pointing only at x=0, the hsync window, the in-frame window, the vsync and interrupt edges at their exact positions, and the hold of each sync flag between events. Some behaviour only shows over a whole frame or across a reset, and only the scoreboard scenarios cover it. That covers the full shape of the vsync pulse across several lines and its mid-line end, the interrupt staying high through the frame wrap, and the first position after reset differing from later (0,0) positions. It also covers the restart from a mid-frame reset.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // One decoded raster event set per position
  typedef struct packed {
    logic hs_on;
    logic hs_off;
    logic vs_on;
    logic vs_off;
    logic irq_set;
    logic irq_clr;
  } raster_evt_t;

endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
  parameter int H_MAX = 1023,
  parameter int V_MAX = 311,
  localparam int XW = $clog2(H_MAX + 1),
  localparam int YW = $clog2(V_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic [XW-1:0] x_nxt_o,
  output logic [YW-1:0] y_nxt_o,
  output logic          eol_o
);

  localparam logic [XW-1:0] X_LAST = XW'(H_MAX);
  localparam logic [YW-1:0] Y_LAST = YW'(V_MAX);

  logic [XW-1:0] x_q, x_nxt;
  logic [YW-1:0] y_q, y_nxt;
  logic          x_wrap;
  logic          eol_q;

  always_comb begin
    x_wrap = (x_q == X_LAST);
    x_nxt  = x_wrap ? '0 : x_q + 1'b1;
    y_nxt  = y_q;
    if (x_wrap) begin
      y_nxt = (y_q == Y_LAST) ? '0 : y_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q   <= '0;
      y_q   <= '0;
      eol_q <= 1'b0;
    end else begin
      x_q   <= x_nxt;
      y_q   <= y_nxt;
      eol_q <= x_wrap;
    end
  end

  assign x_o     = x_q;
  assign y_o     = y_q;
  assign x_nxt_o = x_nxt;
  assign y_nxt_o = y_nxt;
  assign eol_o   = eol_q;

  p_x_step_r2: assert property (@(posedge clk) disable iff (rst)
    (x_q != X_LAST) |=> (x_q == $past(x_q) + 1'b1));
  p_x_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (x_q == X_LAST) |=> (x_q == '0));
  p_y_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (x_q != X_LAST) |=> $stable(y_q));
  p_y_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (x_q == X_LAST && y_q == Y_LAST) |=> (y_q == '0));
  p_eol_follow_r4: assert property (@(posedge clk) disable iff (rst)
    (x_q == X_LAST) |=> eol_q);

endmodule

// File: rtl/raster_event_decode.sv
module raster_event_decode
  import raster_pkg::*;
#(
  parameter int H_MAX          = 1023,
  parameter int V_MAX          = 311,
  parameter int HSYNC_END      = 75,
  parameter int VSYNC_END_LINE = 2,
  parameter int LAST_PIX_LINE  = 256,
  localparam int XW = $clog2(H_MAX + 1),
  localparam int YW = $clog2(V_MAX + 1)
) (
  input  logic [XW-1:0] x_i,
  input  logic [YW-1:0] y_i,
  output raster_evt_t   evt_o
);

  localparam logic [XW-1:0] X_HS_END = XW'(HSYNC_END);
  localparam logic [XW-1:0] X_HALF   = XW'(H_MAX / 2);
  localparam logic [YW-1:0] Y_VS_END = YW'(VSYNC_END_LINE);
  localparam logic [YW-1:0] Y_IRQ    = YW'(LAST_PIX_LINE);

  // Priority: line start first, then hsync end, then mid-line vsync end
  always_comb begin
    evt_o = '0;
    if (x_i == '0) begin
      evt_o.hs_on = 1'b1;
      if (y_i == '0) begin
        evt_o.vs_on   = 1'b1;
        evt_o.irq_clr = 1'b1;
      end else if (y_i == Y_IRQ) begin
        evt_o.irq_set = 1'b1;
      end
    end else if (x_i == X_HS_END) begin
      evt_o.hs_off = 1'b1;
    end else if (y_i == Y_VS_END && x_i == X_HALF) begin
      evt_o.vs_off = 1'b1;
    end
  end

endmodule

// File: rtl/raster_flag.sv
module raster_flag #(
  parameter bit ON_LEVEL  = 1'b1,
  parameter bit RST_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic on_i,
  input  logic off_i,
  output logic q_o
);

  logic q;

  always_ff @(posedge clk) begin
    if (rst)        q <= RST_LEVEL;
    else if (on_i)  q <= ON_LEVEL;
    else if (off_i) q <= ~ON_LEVEL;
  end

  assign q_o = q;

  // Sync and interrupt levels hold between their events (R5, R6, R7)
  p_flag_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!on_i && !off_i) |=> $stable(q));

endmodule

// File: rtl/raster_window.sv
module raster_window #(
  parameter int H_MAX         = 1023,
  parameter int V_MAX         = 311,
  parameter int LAST_PIX_LINE = 256,
  parameter int PIX_XMIN      = 128,
  parameter int PIX_XMAX      = 768,
  localparam int XW = $clog2(H_MAX + 1),
  localparam int YW = $clog2(V_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [XW-1:0] x_nxt_i,
  input  logic [YW-1:0] y_nxt_i,
  output logic          in_frame_o
);

  localparam bit RST_IN = (LAST_PIX_LINE > 0) && (PIX_XMIN == 0);

  logic in_q;

  // Registered from next position so it lines up with x_o / y_o
  always_ff @(posedge clk) begin
    if (rst) begin
      in_q <= RST_IN;
    end else begin
      in_q <= (int'(y_nxt_i) < LAST_PIX_LINE) &&
              (int'(x_nxt_i) >= PIX_XMIN) &&
              (int'(x_nxt_i) < PIX_XMAX);
    end
  end

  assign in_frame_o = in_q;

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import raster_pkg::*;
#(
  parameter int H_MAX          = 1023,
  parameter int V_MAX          = 311,
  parameter int HSYNC_END      = 75,
  parameter int VSYNC_END_LINE = 2,
  parameter int LAST_PIX_LINE  = 256,
  parameter int PIX_XMIN       = 128,
  parameter int PIX_XMAX       = 768,
  localparam int XW = $clog2(H_MAX + 1),
  localparam int YW = $clog2(V_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          hsync_n_o,
  output logic          vsync_n_o,
  output logic          irq_o,
  output logic          eol_o,
  output logic          in_frame_o,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o
);

  localparam int X_HALF = H_MAX / 2;

  logic [XW-1:0] x_cur, x_nxt;
  logic [YW-1:0] y_cur, y_nxt;
  raster_evt_t   evt;

  raster_counter #(.H_MAX(H_MAX), .V_MAX(V_MAX)) u_cnt (
    .clk(clk), .rst(rst),
    .x_o(x_cur), .y_o(y_cur),
    .x_nxt_o(x_nxt), .y_nxt_o(y_nxt),
    .eol_o(eol_o)
  );

  raster_event_decode #(
    .H_MAX(H_MAX), .V_MAX(V_MAX), .HSYNC_END(HSYNC_END),
    .VSYNC_END_LINE(VSYNC_END_LINE), .LAST_PIX_LINE(LAST_PIX_LINE)
  ) u_dec (
    .x_i(x_cur), .y_i(y_cur), .evt_o(evt)
  );

  raster_flag #(.ON_LEVEL(1'b0), .RST_LEVEL(1'b1)) u_hs (
    .clk(clk), .rst(rst), .on_i(evt.hs_on), .off_i(evt.hs_off), .q_o(hsync_n_o)
  );

  raster_flag #(.ON_LEVEL(1'b0), .RST_LEVEL(1'b1)) u_vs (
    .clk(clk), .rst(rst), .on_i(evt.vs_on), .off_i(evt.vs_off), .q_o(vsync_n_o)
  );

  raster_flag #(.ON_LEVEL(1'b1), .RST_LEVEL(1'b0)) u_irq (
    .clk(clk), .rst(rst), .on_i(evt.irq_set), .off_i(evt.irq_clr), .q_o(irq_o)
  );

  raster_window #(
    .H_MAX(H_MAX), .V_MAX(V_MAX), .LAST_PIX_LINE(LAST_PIX_LINE),
    .PIX_XMIN(PIX_XMIN), .PIX_XMAX(PIX_XMAX)
  ) u_win (
    .clk(clk), .rst(rst), .x_nxt_i(x_nxt), .y_nxt_i(y_nxt), .in_frame_o(in_frame_o)
  );

  assign x_o = x_cur;
  assign y_o = y_cur;

  p_rst_state_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (x_o == '0 && y_o == '0 && hsync_n_o && vsync_n_o && !irq_o && !eol_o));
  p_eol_pos_r4: assert property (@(posedge clk) disable iff (rst)
    eol_o |-> (x_o == '0));
  p_hsync_win_r5: assert property (@(posedge clk) disable iff (rst)
    hsync_n_o == !(int'(x_o) >= 1 && int'(x_o) <= HSYNC_END));
  p_vs_start_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(x_o) == 1 && y_o == '0) |-> !vsync_n_o);
  p_vs_end_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(x_o) == X_HALF + 1 && int'(y_o) == VSYNC_END_LINE) |-> vsync_n_o);
  p_irq_set_r7: assert property (@(posedge clk) disable iff (rst)
    (int'(x_o) == 1 && int'(y_o) == LAST_PIX_LINE) |-> irq_o);
  p_irq_clr_r7: assert property (@(posedge clk) disable iff (rst)
    (int'(x_o) == 1 && y_o == '0) |-> !irq_o);
  p_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
    in_frame_o == (int'(y_o) < LAST_PIX_LINE && int'(x_o) >= PIX_XMIN &&
                   int'(x_o) < PIX_XMAX));

endmodule

// File: tb/tb_raster_sync_gen.sv
module tb_raster_sync_gen;

  localparam int H    = 31;
  localparam int V    = 11;
  localparam int HSE  = 4;
  localparam int VSE  = 2;
  localparam int LAST = 8;
  localparam int XMIN = 4;
  localparam int XMAX = 24;
  localparam int FRAME = (H + 1) * (V + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync_n_o, vsync_n_o, irq_o, eol_o, in_frame_o;
  logic [4:0] x_o;
  logic [3:0] y_o;

  always #10 clk = ~clk;

  raster_sync_gen #(
    .H_MAX(H), .V_MAX(V), .HSYNC_END(HSE), .VSYNC_END_LINE(VSE),
    .LAST_PIX_LINE(LAST), .PIX_XMIN(XMIN), .PIX_XMAX(XMAX)
  ) dut (
    .clk(clk), .rst(rst), .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o),
    .irq_o(irq_o), .eol_o(eol_o), .in_frame_o(in_frame_o), .x_o(x_o), .y_o(y_o)
  );

  typedef struct {
    int k;
    int x;
    int y;
    int hs_n;
    int vs_n;
    int irq;
    int eol;
    int inf;
  } exp_t;

  exp_t q[$];
  int tests = 0;
  int fails = 0;
  int k = 0;
  bit done = 0;

  // Expected outputs for the k-th position after reset release (k >= 1)
  function automatic exp_t model(int kk);
    exp_t e;
    e.k    = kk;
    e.x    = kk % (H + 1);
    e.y    = (kk / (H + 1)) % (V + 1);
    e.eol  = (e.x == 0);
    e.hs_n = !(e.x >= 1 && e.x <= HSE);
    e.vs_n = !((e.y < VSE && !(e.y == 0 && e.x == 0)) || (e.y == VSE && e.x <= H / 2));
    e.irq  = (e.y == LAST && e.x >= 1) || (e.y > LAST) || (e.y == 0 && e.x == 0);
    e.inf  = (e.y < LAST) && (e.x >= XMIN) && (e.x < XMAX);
    return e;
  endfunction

  task automatic chk(string req, string what, int act, int exp, int kk);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at k=%0d: actual %0d expected %0d", req, what, kk, act, exp);
    end
  endtask

  task automatic check_reset_state(string req);
    chk(req, "x_o", int'(x_o), 0, 0);
    chk(req, "y_o", int'(y_o), 0, 0);
    chk(req, "hsync_n_o", int'(hsync_n_o), 1, 0);
    chk(req, "vsync_n_o", int'(vsync_n_o), 1, 0);
    chk(req, "irq_o", int'(irq_o), 0, 0);
    chk(req, "eol_o", int'(eol_o), 0, 0);
    chk(req, "in_frame_o", int'(in_frame_o), 0, 0);
  endtask

  // Driver: one expected item per active clock edge
  task automatic run(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
      k++;
      q.push_back(model(k));
    end
  endtask

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk("R2", "x_o", int'(x_o), e.x, e.k);
      chk("R3", "y_o", int'(y_o), e.y, e.k);
      chk("R4", "eol_o", int'(eol_o), e.eol, e.k);
      chk("R5", "hsync_n_o", int'(hsync_n_o), e.hs_n, e.k);
      chk("R6", "vsync_n_o", int'(vsync_n_o), e.vs_n, e.k);
      chk("R7", "irq_o", int'(irq_o), e.irq, e.k);
      chk("R8", "in_frame_o", int'(in_frame_o), e.inf, e.k);
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("R1");
    rst = 1'b0;
    k = 0;
    run(3 * FRAME + 5);
    @(negedge clk);
    // Mid-frame reset (R9): position is away from (0,0) here
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset_state("R9");
    rst = 1'b0;
    k = 0;
    run(FRAME + 20);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule